// File: doc/BRIEF.md
# Configurable Asynchronous Character Transmitter

This block turns bytes written by a host into framed asynchronous serial characters on a single output line. A programmable 16-bit divisor sets the rate of a tick pulse that runs at sixteen times the bit rate. Every bit on the line lasts sixteen ticks.

A written byte first goes into a one-character holding register. When the serial shifter is idle, it takes the character from there and frames it. The frame settings come from an 8-bit line control word, which the shifter captures at the start of each character:

- word length of 5 to 8 bits;
- optional parity, which is odd, even, or forced to a constant;
- one, one and a half, or two stop bits.

A break control drives the line to the space level for as long as it is set. When the divisor-access bit of the line control word is set, byte writes go to the divisor latch, which lies outside this block, and the holding register ignores them. Two flags report progress:
- one rises as soon as the holding register can take another byte;
- the other rises only when nothing at all is left to send.

Top module: `serial_tx_core`

## Requirements
- R1: After reset the serial line is at mark (1), and both the holding-empty flag and the fully-empty flag read 1.
- R2: Each bit on the line lasts 16 ticks, and one tick occurs every D clock cycles, where D is the divisor value. A bit therefore lasts 16*D clock cycles.
- R3: A frame starts with a start bit of 0. The data bits follow, least significant first. Their count is set by line_ctrl[1:0]: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R4: With line_ctrl[3]=1 and line_ctrl[5]=0, a parity bit follows the data bits. line_ctrl[4]=0 makes the total count of ones in the data and parity bits odd, and line_ctrl[4]=1 makes it even. With line_ctrl[3]=0, no parity bit is sent.
- R5: With line_ctrl[3]=1 and line_ctrl[5]=1, the parity bit is a constant: 1 when line_ctrl[4]=0 and 0 when line_ctrl[4]=1.
- R6: The stop period is at mark. With line_ctrl[2]=0 it lasts 16 ticks. With line_ctrl[2]=1 it lasts 32 ticks for 6-, 7- and 8-bit words and 24 ticks for 5-bit words.
- R7: While line_ctrl[6]=1, the serial line is at space (0) regardless of the state of the transmitter.
- R8: A byte write to an idle transmitter clears the holding-empty flag for one cycle. The flag sets again when the shifter takes the byte, even though the frame is still being sent.
- R9: The fully-empty flag stays 0 from the write until the last stop tick ends, and it is never 1 while the holding-empty flag is 0.
- R10: A byte write while line_ctrl[7]=1 does not reach the holding register. The flags stay at 1 and no frame is sent.
- R11: A pulse on div_wr restarts the tick counter. The first tick after the pulse comes D cycles after the edge at which div_wr was sampled.
- R12: A divisor value of 0 behaves exactly like a divisor of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_wr | input | 1 | Byte write strobe toward the holding register |
| char_data | input | 8 | Byte to send |
| line_ctrl | input | 8 | Line control word: length, stop, parity, break and divisor access |
| div_latch | input | 16 | Divisor latch value (0 behaves as 1) |
| div_wr | input | 1 | Pulse when either divisor byte is written; restarts the tick counter |
| txd | output | 1 | Serial line, idle at mark |
| thr_empty | output | 1 | Holding register is free |
| tx_empty | output | 1 | Holding register and shifter are both idle |

## Verification
The holding-empty flag drops on the cycle after the write edge and rises again one cycle later. The fully-empty flag drops with the write and rises when the shifter returns to idle, which is D times the frame's tick count after the load, give or take up to D-1 cycles of tick phase. The bench therefore counts cycles from the write and samples each line bit at its nominal middle, 16*D*j + 8*D cycles after the start bit appears. This point is clear of any boundary shift that the unknown tick phase can cause. The frame length is checked against a window that is exactly as wide as that phase uncertainty. After a divisor restart the phase is fixed, so the start-to-first-data-bit boundary is checked at its exact cycle.

// File: rtl/serial_tx_pkg.sv
// Shared types and helpers for the serial transmitter.
// Assumes the line control word layout fixed by the requirements.
package serial_tx_pkg;

    localparam int TICKS_PER_BIT = 16;
    localparam int TCNT_W        = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic       brk;        // force space
        logic       stick;      // constant parity
        logic       even;       // even parity select
        logic       par_en;     // parity bit present
        logic       stop_long;  // 1.5 / 2 stop bits
        logic [1:0] wlen;       // 5 + wlen data bits
    } frame_cfg_t;

    // Split the line control word into named fields.
    function automatic frame_cfg_t decode_cfg(input logic [7:0] lc);
        frame_cfg_t c;
        c.wlen      = lc[1:0];
        c.stop_long = lc[2];
        c.par_en    = lc[3];
        c.even      = lc[4];
        c.stick     = lc[5];
        c.brk       = lc[6];
        return c;
    endfunction

    // Length of the stop period in ticks.
    function automatic logic [TCNT_W-1:0] stop_ticks(input frame_cfg_t c);
        if (!c.stop_long)      return TCNT_W'(TICKS_PER_BIT);
        else if (c.wlen == 2'b00) return TCNT_W'(TICKS_PER_BIT + TICKS_PER_BIT/2);
        else                   return TCNT_W'(2*TICKS_PER_BIT);
    endfunction

endpackage

// File: rtl/tx_baud_gen.sv
// Tick generator: one tick every max(div_i,1) clock cycles.
// Assumes restart_i pulses whenever a divisor byte is written; the tick is
// suppressed on that cycle and the count begins again from zero.
module tx_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             restart_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    // Terminal count: a divisor of zero behaves as one.
    always_comb begin
        lim = (div_i == '0) ? '0 : div_i - DIV_W'(1);
    end

    assign tick_o = (cnt_q >= lim) && !restart_i;

    // Free-running counter, cleared on reset, restart or terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (restart_i)    cnt_q <= '0;
        else if (cnt_q >= lim) cnt_q <= '0;
        else                   cnt_q <= cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/tx_hold_reg.sv
// One-character holding register between the host and the shifter.
// A write while full replaces the held byte; a write on the take cycle
// keeps the new byte held while the shifter loads the old one.
module tx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              take_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);
    logic              full_q;
    logic [DATA_W-1:0] data_q;

    // Track occupancy: writes fill, shifter takes drain.
    always_ff @(posedge clk) begin
        if (!rst_n)      full_q <= 1'b0;
        else if (wr_i)   full_q <= 1'b1;
        else if (take_i) full_q <= 1'b0;
    end

    // Capture written data.
    always_ff @(posedge clk) begin
        if (!rst_n)    data_q <= '0;
        else if (wr_i) data_q <= data_i;
    end

    assign full_o = full_q;
    assign data_o = data_q;
endmodule

// File: rtl/tx_frame_shifter.sv
// Frames one character: start, data LSB first, optional parity, stop.
// Captures the frame settings on load so mid-frame changes do not tear
// a character. Advances only on ticks; each state lasts a tick count.
module tx_frame_shifter
    import serial_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  frame_cfg_t        cfg_i,
    output logic              busy_o,
    output logic              line_o
);
    localparam int BIDX_W = $clog2(DATA_W + 1);

    tx_state_e          state_q;
    logic [DATA_W-1:0]  sh_q;
    logic [BIDX_W-1:0]  bidx_q;
    logic [BIDX_W-1:0]  nbits_q;
    logic [TCNT_W-1:0]  tcnt_q;
    logic [TCNT_W-1:0]  stop_lim_q;
    logic               par_en_q;
    logic               par_q;

    logic [BIDX_W-1:0]  nbits_w;
    logic [DATA_W-1:0]  word_mask;
    logic               raw_par;
    logic               par_w;
    logic [TCNT_W-1:0]  cur_lim;
    logic               bit_done;

    // Number of data bits requested by the line control word.
    assign nbits_w = BIDX_W'(5) + BIDX_W'(cfg_i.wlen);

    // Mask of the data bits that belong to the word.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign word_mask[g] = (nbits_w > BIDX_W'(g));
    end

    // Parity of the word and the bit to send for the chosen mode.
    always_comb begin
        raw_par = ^(data_i & word_mask);
        if (cfg_i.stick)     par_w = ~cfg_i.even;
        else if (cfg_i.even) par_w = raw_par;
        else                 par_w = ~raw_par;
    end

    // Ticks in the current state and end-of-bit detect.
    always_comb begin
        cur_lim  = (state_q == ST_STOP) ? stop_lim_q : TCNT_W'(TICKS_PER_BIT);
        bit_done = tick_i && (tcnt_q == cur_lim - TCNT_W'(1));
    end

    // Frame sequencing and tick counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            sh_q       <= '0;
            bidx_q     <= '0;
            nbits_q    <= '0;
            tcnt_q     <= '0;
            stop_lim_q <= TCNT_W'(TICKS_PER_BIT);
            par_en_q   <= 1'b0;
            par_q      <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (load_i) begin
                state_q    <= ST_START;
                sh_q       <= data_i;
                nbits_q    <= nbits_w;
                stop_lim_q <= stop_ticks(cfg_i);
                par_en_q   <= cfg_i.par_en;
                par_q      <= par_w;
                tcnt_q     <= '0;
                bidx_q     <= '0;
            end
        end else if (tick_i) begin
            if (!bit_done) begin
                tcnt_q <= tcnt_q + TCNT_W'(1);
            end else begin
                tcnt_q <= '0;
                unique case (state_q)
                    ST_START: begin
                        state_q <= ST_DATA;
                        bidx_q  <= '0;
                    end
                    ST_DATA: begin
                        sh_q   <= sh_q >> 1;
                        bidx_q <= bidx_q + BIDX_W'(1);
                        if (bidx_q == nbits_q - BIDX_W'(1))
                            state_q <= par_en_q ? ST_PAR : ST_STOP;
                    end
                    ST_PAR:  state_q <= ST_STOP;
                    ST_STOP: state_q <= ST_IDLE;
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // Line level for the current state.
    always_comb begin
        unique case (state_q)
            ST_START: line_o = 1'b0;
            ST_DATA:  line_o = sh_q[0];
            ST_PAR:   line_o = par_q;
            default:  line_o = 1'b1;
        endcase
    end

    assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/serial_tx_core.sv
// Transmit path top: tick generator, holding register and frame shifter.
// Byte writes are steered away while the divisor-access bit is set; the
// break bit overrides the line combinationally.
module serial_tx_core
    import serial_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_wr,
    input  logic [DATA_W-1:0] char_data,
    input  logic [7:0]        line_ctrl,
    input  logic [DIV_W-1:0]  div_latch,
    input  logic              div_wr,
    output logic              txd,
    output logic              thr_empty,
    output logic              tx_empty
);
    frame_cfg_t        cfg;
    logic              baud_tick;
    logic              hold_wr;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              busy;
    logic              shift_line;

    assign cfg     = decode_cfg(line_ctrl);
    assign hold_wr = char_wr && !line_ctrl[7];
    assign take    = hold_full && !busy;

    tx_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_i     (div_latch),
        .restart_i (div_wr),
        .tick_o    (baud_tick)
    );

    tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (hold_wr),
        .data_i (char_data),
        .take_i (take),
        .full_o (hold_full),
        .data_o (hold_data)
    );

    tx_frame_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (baud_tick),
        .load_i (take),
        .data_i (hold_data),
        .cfg_i  (cfg),
        .busy_o (busy),
        .line_o (shift_line)
    );

    assign txd       = shift_line && !cfg.brk;
    assign thr_empty = !hold_full;
    assign tx_empty  = !hold_full && !busy;
endmodule

// File: rtl/serial_tx_chk.sv
// Assertion checker for serial_tx_core, attached by bind.
module serial_tx_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             char_wr,
    input logic [7:0]       line_ctrl,
    input logic [DIV_W-1:0] div_latch,
    input logic             div_wr,
    input logic             txd,
    input logic             thr_empty,
    input logic             tx_empty,
    input logic             baud_tick
);
    // R1
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !line_ctrl[6]) |-> txd);

    // R9
    flag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> thr_empty);

    // R8
    hold_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_wr && !line_ctrl[7]) |=> !thr_empty);

    // R10
    dlab_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_wr && line_ctrl[7] && thr_empty) |=> thr_empty);

    // R11
    restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_wr && div_latch > DIV_W'(1)) |=> !baud_tick);

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick && !div_wr && div_latch > DIV_W'(1)) |=>
            (!baud_tick || div_latch != $past(div_latch)));
endmodule

bind serial_tx_core serial_tx_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .char_wr   (char_wr),
    .line_ctrl (line_ctrl),
    .div_latch (div_latch),
    .div_wr    (div_wr),
    .txd       (txd),
    .thr_empty (thr_empty),
    .tx_empty  (tx_empty),
    .baud_tick (baud_tick)
);

// File: tb/serial_tx_core_tb.sv
// Self-checking bench: directed corners plus seeded random frames.
module serial_tx_core_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        char_wr;
    logic [7:0]  char_data;
    logic [7:0]  line_ctrl;
    logic [15:0] div_latch;
    logic        div_wr;
    logic        txd, thr_empty, tx_empty;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    serial_tx_core u_dut (
        .clk(clk), .rst_n(rst_n), .char_wr(char_wr), .char_data(char_data),
        .line_ctrl(line_ctrl), .div_latch(div_latch), .div_wr(div_wr),
        .txd(txd), .thr_empty(thr_empty), .tx_empty(tx_empty)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic par_bit(input logic [7:0] d, input logic [5:0] cfg);
        logic [7:0] m;
        logic p;
        m = 8'hFF >> (3 - cfg[1:0]);
        p = ^(d & m);
        if (cfg[5])      return ~cfg[4];
        else if (cfg[4]) return p;
        else             return ~p;
    endfunction

    function automatic int stop_len(input logic [5:0] cfg);
        if (!cfg[2])             return 16;
        else if (cfg[1:0] == 0)  return 24;
        else                     return 32;
    endfunction

    // Send one byte and check every bit of the frame plus both flags.
    task automatic run_frame(input logic [7:0] d, input logic [5:0] cfg,
                             input logic [15:0] dv, input bit restart, input string len_tag);
        int effd, nb, pe, nbit, tt, c, lo, hi;
        logic exp_bits [0:10];
        string tag [0:10];
        effd = (dv == 0) ? 1 : int'(dv);
        nb   = 5 + int'(cfg[1:0]);
        pe   = int'(cfg[3]);
        nbit = 2 + nb + pe;
        exp_bits[0] = 1'b0; tag[0] = "R3 start";
        for (int k = 0; k < nb; k++) begin exp_bits[1+k] = d[k]; tag[1+k] = "R3 data"; end
        if (pe != 0) begin
            exp_bits[1+nb] = par_bit(d, cfg);
            tag[1+nb] = cfg[5] ? "R5 parity" : "R4 parity";
        end
        exp_bits[nbit-1] = 1'b1; tag[nbit-1] = "R6 stop";
        tt = (1 + nb + pe) * 16 + stop_len(cfg);
        lo = tt * effd - effd + 2;
        hi = tt * effd + 1;

        @(negedge clk);
        div_latch = dv;
        line_ctrl = {2'b00, cfg};
        char_data = d;
        char_wr   = 1'b1;
        div_wr    = restart;
        @(negedge clk);
        char_wr = 1'b0;
        div_wr  = 1'b0;
        c = 1;
        check(thr_empty == 1'b0, "R8 held", int'(thr_empty), 0);
        while (tx_empty == 1'b0 && c < 8000) begin
            if (c == 2) begin
                check(thr_empty == 1'b1, "R8 freed", int'(thr_empty), 1);
                check(tx_empty == 1'b0, "R9 busy", int'(tx_empty), 0);
            end
            for (int j = 0; j < nbit; j++)
                if (c == 2 + (16*j + 8) * effd)
                    check(txd == exp_bits[j], tag[j], int'(txd), int'(exp_bits[j]));
            if (restart && effd == 4 && c == 64)
                check(txd == 1'b0, "R11 start end", int'(txd), 0);
            if (restart && effd == 4 && c == 65)
                check(txd == d[0], "R11 first data", int'(txd), int'(d[0]));
            @(negedge clk);
            c++;
        end
        check((c - 1) >= lo && (c - 1) <= hi, len_tag, c - 1, tt * effd);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [5:0] rc;
        rst_n = 1'b0; char_wr = 1'b0; char_data = '0;
        line_ctrl = 8'h03; div_latch = 16'd1; div_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 line", int'(txd), 1);
        check(thr_empty == 1'b1, "R1 thr", int'(thr_empty), 1);
        check(tx_empty == 1'b1, "R1 empty", int'(tx_empty), 1);

        // R2 timing, R3 order, R4 odd/even, R5 sticky, R6 stop lengths
        run_frame(8'hA5, 6'b000011, 16'd1, 1'b0, "R2 len d1");
        run_frame(8'h3C, 6'b001011, 16'd3, 1'b0, "R2 len d3");
        run_frame(8'h17, 6'b011010, 16'd2, 1'b0, "R6 len");
        run_frame(8'h15, 6'b101100, 16'd1, 1'b0, "R6 5bit 1.5");
        run_frame(8'h2A, 6'b111101, 16'd2, 1'b0, "R6 6bit 2");
        run_frame(8'h81, 6'b001111, 16'd1, 1'b0, "R6 8bit 2");
        // R12 divisor zero
        run_frame(8'h5A, 6'b000011, 16'd0, 1'b0, "R12 len d0");
        // R11 restart fixes tick phase
        run_frame(8'hC3, 6'b000011, 16'd4, 1'b1, "R11 len");

        // R7 break forces space while set
        @(negedge clk);
        line_ctrl = 8'h43;
        @(negedge clk);
        check(txd == 1'b0, "R7 break", int'(txd), 0);
        line_ctrl = 8'h03;
        @(negedge clk);
        check(txd == 1'b1, "R7 release", int'(txd), 1);

        // R10 writes with divisor access set are ignored
        line_ctrl = 8'h83;
        char_data = 8'hEE;
        char_wr   = 1'b1;
        @(negedge clk);
        char_wr = 1'b0;
        check(thr_empty == 1'b1, "R10 thr", int'(thr_empty), 1);
        repeat (40) @(negedge clk);
        check(tx_empty == 1'b1, "R10 empty", int'(tx_empty), 1);
        check(txd == 1'b1, "R10 line", int'(txd), 1);
        run_frame(8'h0F, 6'b000011, 16'd1, 1'b0, "R10 next len");

        // Seeded random frames
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 30; i++) begin
            rc = 6'($urandom);
            run_frame(8'($urandom), rc, 16'($urandom % 4), 1'b0, "R6 rnd len");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule